// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns a fast peripheral clock into the bit timing that an I2C master engine uses. A prescaler divides the peripheral clock by one plus a small divider value to make an internal tick. The tick should stay under 20 MHz. The SCL period is counted in those ticks. Its base length is 20 ticks plus 8 ticks for each step of a 6-bit period field. The base length is split evenly between a driven-low phase and a released-high phase.

The high phase is counted only after the synchronized SCL line is seen high. The time the bus takes to rise is therefore added to the period. A slave that holds SCL low stretches the period in the same way. When the master is enabled, a programmable first-bit setup interval runs before the first falling edge of SCL, with SCL still released.

The block gives the byte engine one-cycle strobes for these events:
- SCL has just gone low.
- The high count has just started.
- SDA may change, at the middle of the low phase.
- SDA should be sampled, at the middle of the high phase.

Two small write/readback registers hold the divider settings.

Top module: `scl_timing_gen`

## Requirements
- R1: The clock-control register sits at offset 0x18. It holds the divider value in bits [2:0] and the period value in bits [8:3]. A readback returns those fields with every other bit zero. A write to any other offset leaves the register unchanged.
- R2: The setup register sits at offset 0x38 and holds its value in bits [3:0]. After enable, SCL stays released for (value + 2) ticks before it is first driven low, so 15 gives 17 ticks.
- R3: One internal tick occurs every (1 + divider) peripheral clock cycles. The prescaler is cleared while the block is disabled and again when each high phase begins.
- R4: Each low phase drives SCL low for exactly (20 + 8·period)/2 ticks, which is that count times (1 + divider) clock cycles. SCL is driven low only on a tick.
- R5: After SCL is released, the high count does not start until the synchronized SCL input reads high. A held-low line therefore delays the high strobe for as long as it is held.
- R6: Each high phase lasts (20 + 8·period)/2 ticks from its start. SCL is then driven low again.
- R7: Exactly one SDA-change pulse occurs in each low phase, and one SDA-sample pulse in each high phase. Each comes one cycle after the tick on which the phase count equals half the phase length. At most one strobe is active in any cycle.
- R8: The fall strobe is high in the first cycle that SCL is driven low. The high strobe is high in the first cycle of the high count.
- R9: One cycle after enable goes low, SCL is released and every strobe is low. A later enable starts again with the setup interval.
- R10: After reset, SCL is released, all strobes are low and both registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Master enable; low holds the timing in reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write offset |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register readback offset |
| rd_data_o | output | DATA_W | Register readback data |
| scl_i | input | 1 | Observed SCL bus level |
| scl_oe_o | output | 1 | High to pull SCL low |
| fall_stb_o | output | 1 | First cycle of the low phase |
| high_stb_o | output | 1 | First cycle of the high count |
| sda_chg_o | output | 1 | SDA may change now |
| sda_smp_o | output | 1 | Sample SDA now |

## Verification
The bench builds the block with its default parameters: a 3-bit divider field, a 6-bit period field, a two-stage SCL synchronizer and the setup register present. These values make the extremes reachable. The largest divider and period give a 2096-cycle low phase, and the largest setup value gives 17 setup ticks. Because the synchronizer depth is fixed, a bus model with a set rise delay and a stretch switch sees a known delay between release and the high strobe. The cycle model is compared on every clock across the smallest, a middle and the largest divider settings, and across disables that cut into a phase.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_SETUP = 3'd1,
      PH_LOW   = 3'd2,
      PH_WAIT  = 3'd3,
      PH_HIGH  = 3'd4
   } scl_phase_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/scl_clk_regs.sv
module scl_clk_regs #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CDF_W         = 3,
   parameter int unsigned SCGD_W        = 6,
   parameter int unsigned SCGD_LSB      = 3,
   parameter int unsigned FBS_W         = 4,
   parameter int unsigned FBS_EXTRA     = 2,
   parameter int unsigned CNT_W         = 9,
   parameter int unsigned CCR_OFFSET    = 'h18,
   parameter int unsigned FBS_OFFSET    = 'h38,
   parameter int unsigned HAS_FIRST_BIT = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic [CDF_W-1:0]  cdf_o,
   output logic [SCGD_W-1:0] scgd_o,
   output logic [CNT_W-1:0]  setup_ticks_o
);

   localparam logic [ADDR_W-1:0] CCR_A = ADDR_W'(CCR_OFFSET);
   localparam logic [ADDR_W-1:0] FBS_A = ADDR_W'(FBS_OFFSET);

   if (CDF_W > SCGD_LSB) begin : g_chk_cdf
      $error("divider field overlaps period field");
   end
   if (DATA_W < SCGD_LSB + SCGD_W || DATA_W < FBS_W) begin : g_chk_data
      $error("data bus narrower than register fields");
   end
   if (CCR_OFFSET == FBS_OFFSET) begin : g_chk_addr
      $error("register offsets collide");
   end
   if (FBS_EXTRA < 1) begin : g_chk_extra
      $error("setup interval must be at least one tick");
   end

   logic [CDF_W-1:0]  cdf_q;
   logic [SCGD_W-1:0] scgd_q;
   logic [FBS_W-1:0]  fbs_q;
   logic              ccr_hit, fbs_hit;
   logic              unused_wdata;

   assign ccr_hit      = wr_en_i && (wr_addr_i == CCR_A);
   assign fbs_hit      = wr_en_i && (wr_addr_i == FBS_A);
   assign unused_wdata = ^wr_data_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cdf_q  <= '0;
         scgd_q <= '0;
      end else if (ccr_hit) begin
         cdf_q  <= wr_data_i[CDF_W-1:0];
         scgd_q <= wr_data_i[SCGD_LSB +: SCGD_W];
      end
   end

   if (HAS_FIRST_BIT != 0) begin : g_fbs
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      fbs_q <= '0;
         else if (fbs_hit) fbs_q <= wr_data_i[FBS_W-1:0];
      end
      assign setup_ticks_o = CNT_W'(fbs_q) + CNT_W'(FBS_EXTRA);
   end else begin : g_no_fbs
      assign fbs_q         = '0;
      assign setup_ticks_o = CNT_W'(1);
   end

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == CCR_A) begin
         rd_data_o[CDF_W-1:0]           = cdf_q;
         rd_data_o[SCGD_LSB +: SCGD_W]  = scgd_q;
      end else if (rd_addr_i == FBS_A) begin
         rd_data_o[FBS_W-1:0]           = fbs_q;
      end
   end

   assign cdf_o  = cdf_q;
   assign scgd_o = scgd_q;

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
   parameter int unsigned CDF_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [CDF_W-1:0] cdf_i,
   output logic             tick_o
);

   if (CDF_W < 1) begin : g_chk_w
      $error("divider field needs at least one bit");
   end

   logic [CDF_W-1:0] pre_q;
   logic             at_limit;

   assign at_limit = (pre_q >= cdf_i);
   assign tick_o   = run_i && at_limit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pre_q <= '0;
      else if (!run_i || restart_i) pre_q <= '0;
      else if (at_limit)          pre_q <= '0;
      else                        pre_q <= pre_q + 1'b1;
   end

   // R3: with a non-zero divider two ticks never sit in adjacent cycles
   p_tick_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && cdf_i != '0) |=> (!tick_o || cdf_i == '0));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
   import scl_timing_pkg::*;
#(
   parameter int unsigned SCGD_W     = 6,
   parameter int unsigned CNT_W      = 9,
   parameter int unsigned BASE_TICKS = 20,
   parameter int unsigned STEP_TICKS = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic              scl_hi_i,
   input  logic [SCGD_W-1:0] scgd_i,
   input  logic [CNT_W-1:0]  setup_ticks_i,
   output logic              run_o,
   output logic              restart_o,
   output logic              scl_oe_o,
   output logic              fall_stb_o,
   output logic              high_stb_o,
   output logic              sda_chg_o,
   output logic              sda_smp_o
);

   localparam int unsigned BASE_HALF = BASE_TICKS / 2;
   localparam int unsigned STEP_HALF = STEP_TICKS / 2;

   if ((BASE_TICKS % 2) != 0 || (STEP_TICKS % 2) != 0) begin : g_chk_even
      $error("base and step counts must be even");
   end
   if (BASE_TICKS < 8) begin : g_chk_base
      $error("base count too small for mid-phase strobes");
   end

   scl_phase_e       state_q, state_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, half, mid;
   logic             fall_d, high_d, chg_d, smp_d;
   logic             fall_q, high_q, chg_q, smp_q;

   assign half = CNT_W'(BASE_HALF) + CNT_W'(STEP_HALF) * CNT_W'(scgd_i);
   assign mid  = half >> 1;

   always_comb begin
      state_d   = state_q;
      cnt_d     = cnt_q;
      fall_d    = 1'b0;
      high_d    = 1'b0;
      chg_d     = 1'b0;
      smp_d     = 1'b0;
      restart_o = 1'b0;
      unique case (state_q)
         PH_IDLE: begin
            state_d = PH_SETUP;
            cnt_d   = '0;
         end
         PH_SETUP: begin
            if (tick_i) begin
               if (cnt_q >= setup_ticks_i - 1'b1) begin
                  state_d = PH_LOW;
                  cnt_d   = '0;
                  fall_d  = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         PH_LOW: begin
            if (tick_i) begin
               chg_d = (cnt_q == mid);
               if (cnt_q >= half - 1'b1) begin
                  state_d = PH_WAIT;
                  cnt_d   = '0;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         PH_WAIT: begin
            if (scl_hi_i) begin
               state_d   = PH_HIGH;
               cnt_d     = '0;
               high_d    = 1'b1;
               restart_o = 1'b1;
            end
         end
         PH_HIGH: begin
            if (tick_i) begin
               smp_d = (cnt_q == mid);
               if (cnt_q >= half - 1'b1) begin
                  state_d = PH_LOW;
                  cnt_d   = '0;
                  fall_d  = 1'b1;
               end else begin
                  cnt_d = cnt_q + 1'b1;
               end
            end
         end
         default: begin
            state_d = PH_IDLE;
            cnt_d   = '0;
         end
      endcase
      if (!en_i) begin
         state_d   = PH_IDLE;
         cnt_d     = '0;
         fall_d    = 1'b0;
         high_d    = 1'b0;
         chg_d     = 1'b0;
         smp_d     = 1'b0;
         restart_o = 1'b0;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= PH_IDLE;
         cnt_q   <= '0;
         fall_q  <= 1'b0;
         high_q  <= 1'b0;
         chg_q   <= 1'b0;
         smp_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         fall_q  <= fall_d;
         high_q  <= high_d;
         chg_q   <= chg_d;
         smp_q   <= smp_d;
      end
   end

   assign run_o      = en_i && (state_q != PH_IDLE);
   assign scl_oe_o   = (state_q == PH_LOW);
   assign fall_stb_o = fall_q;
   assign high_stb_o = high_q;
   assign sda_chg_o  = chg_q;
   assign sda_smp_o  = smp_q;

   // R8: SCL going low is always marked by the fall strobe
   p_fall_marks_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scl_oe_o) |-> fall_stb_o);

   // R4: SCL is only pulled low as the result of a tick
   p_low_after_tick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(scl_oe_o) |-> $past(tick_i));

   // R5: no high count starts while the synchronized line reads low
   p_high_needs_scl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !scl_hi_i |=> !high_stb_o);

   // R9: disabling releases SCL and silences every strobe
   p_released_when_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (!scl_oe_o && !fall_stb_o && !high_stb_o && !sda_chg_o && !sda_smp_o));

   // R7: strobes never overlap
   p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({fall_stb_o, high_stb_o, sda_chg_o, sda_smp_o}));

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
   import scl_timing_pkg::*;
#(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CDF_W         = 3,
   parameter int unsigned SCGD_W        = 6,
   parameter int unsigned SCGD_LSB      = 3,
   parameter int unsigned FBS_W         = 4,
   parameter int unsigned FBS_EXTRA     = 2,
   parameter int unsigned BASE_TICKS    = 20,
   parameter int unsigned STEP_TICKS    = 8,
   parameter int unsigned CCR_OFFSET    = 'h18,
   parameter int unsigned FBS_OFFSET    = 'h38,
   parameter int unsigned HAS_FIRST_BIT = 1,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              scl_i,
   output logic              scl_oe_o,
   output logic              fall_stb_o,
   output logic              high_stb_o,
   output logic              sda_chg_o,
   output logic              sda_smp_o
);

   localparam int unsigned HALF_MAX  = (BASE_TICKS + STEP_TICKS * ((1 << SCGD_W) - 1)) / 2;
   localparam int unsigned SETUP_MAX = ((1 << FBS_W) - 1) + FBS_EXTRA;
   localparam int unsigned CNT_W     = $clog2(max2(HALF_MAX, SETUP_MAX) + 1);

   logic [CDF_W-1:0]  cdf;
   logic [SCGD_W-1:0] scgd;
   logic [CNT_W-1:0]  setup_ticks;
   logic              tick, run, restart, scl_hi;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign scl_hi = scl_i;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sync_q <= '1;
         end else begin
            sync_q[0] <= scl_i;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
         end
      end
      assign scl_hi = sync_q[SYNC_STAGES-1];
   end

   scl_clk_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CDF_W(CDF_W), .SCGD_W(SCGD_W),
      .SCGD_LSB(SCGD_LSB), .FBS_W(FBS_W), .FBS_EXTRA(FBS_EXTRA), .CNT_W(CNT_W),
      .CCR_OFFSET(CCR_OFFSET), .FBS_OFFSET(FBS_OFFSET), .HAS_FIRST_BIT(HAS_FIRST_BIT)
   ) i_regs (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .cdf_o(cdf), .scgd_o(scgd), .setup_ticks_o(setup_ticks)
   );

   scl_prescaler #(.CDF_W(CDF_W)) i_pre (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .restart_i(restart),
      .cdf_i(cdf), .tick_o(tick)
   );

   scl_phase_fsm #(
      .SCGD_W(SCGD_W), .CNT_W(CNT_W), .BASE_TICKS(BASE_TICKS), .STEP_TICKS(STEP_TICKS)
   ) i_fsm (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick), .scl_hi_i(scl_hi),
      .scgd_i(scgd), .setup_ticks_i(setup_ticks), .run_o(run), .restart_o(restart),
      .scl_oe_o(scl_oe_o), .fall_stb_o(fall_stb_o), .high_stb_o(high_stb_o),
      .sda_chg_o(sda_chg_o), .sda_smp_o(sda_smp_o)
   );

endmodule

// File: tb/test_scl_timing_gen.sv
module test_scl_timing_gen;

   localparam int SYNC = 2;
   localparam logic [7:0] CCR = 8'h18;
   localparam logic [7:0] FBS = 8'h38;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        scl_in;
   logic        scl_oe, fall_stb, high_stb, sda_chg, sda_smp;

   int  n_checks = 0;
   int  n_fail = 0;
   bit  cmp_on = 1'b0;
   bit  done = 1'b0;
   bit  stretch = 1'b0;
   int  rise_dly = 2;
   int  rc = 0;

   always #5 clk = ~clk;

   scl_timing_gen #(.SYNC_STAGES(SYNC)) i_scl_timing_gen (
      .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .scl_i(scl_in),
      .scl_oe_o(scl_oe), .fall_stb_o(fall_stb), .high_stb_o(high_stb),
      .sda_chg_o(sda_chg), .sda_smp_o(sda_smp)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // open-drain bus: rises rise_dly cycles after release unless stretched
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_in <= 1'b1;
         rc = 0;
      end else if (scl_oe) begin
         rc = rise_dly;
         scl_in <= 1'b0;
      end else if (stretch) begin
         scl_in <= 1'b0;
      end else if (rc > 0) begin
         rc = rc - 1;
         scl_in <= 1'b0;
      end else begin
         scl_in <= 1'b1;
      end
   end

   // behavioural reference: 0 idle, 1 setup, 2 low, 3 wait, 4 high
   int m_state, m_pre, m_cnt, m_cdf, m_scgd, m_fbs;
   bit m_fall, m_high, m_chg, m_smp;
   int m_sync [SYNC];
   int hf, sl, ns, nc;
   bit tk, run, rp, syn, f, h, c, s;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state = 0; m_pre = 0; m_cnt = 0; m_cdf = 0; m_scgd = 0; m_fbs = 0;
         m_fall = 0; m_high = 0; m_chg = 0; m_smp = 0;
         for (int i = 0; i < SYNC; i++) m_sync[i] = 1;
      end else begin
         run = en && (m_state != 0);
         tk  = run && (m_pre >= m_cdf);
         hf  = (20 + 8 * m_scgd) / 2;
         sl  = m_fbs + 2;
         syn = (m_sync[SYNC-1] == 1);
         ns = m_state; nc = m_cnt; f = 0; h = 0; c = 0; s = 0; rp = 0;
         case (m_state)
            0: begin ns = 1; nc = 0; end
            1: if (tk) begin
                  if (m_cnt >= sl - 1) begin ns = 2; nc = 0; f = 1; end
                  else nc = m_cnt + 1;
               end
            2: if (tk) begin
                  if (m_cnt == hf / 2) c = 1;
                  if (m_cnt >= hf - 1) begin ns = 3; nc = 0; end
                  else nc = m_cnt + 1;
               end
            3: if (syn) begin ns = 4; nc = 0; h = 1; rp = 1; end
            4: if (tk) begin
                  if (m_cnt == hf / 2) s = 1;
                  if (m_cnt >= hf - 1) begin ns = 2; nc = 0; f = 1; end
                  else nc = m_cnt + 1;
               end
            default: ns = 0;
         endcase
         if (!en) begin ns = 0; nc = 0; f = 0; h = 0; c = 0; s = 0; rp = 0; end
         if (!run || rp)        m_pre = 0;
         else if (m_pre >= m_cdf) m_pre = 0;
         else                   m_pre = m_pre + 1;
         m_state = ns; m_cnt = nc;
         m_fall = f; m_high = h; m_chg = c; m_smp = s;
         if (wr_en && wr_addr == CCR) begin
            m_cdf  = int'(wr_data[2:0]);
            m_scgd = int'(wr_data[8:3]);
         end else if (wr_en && wr_addr == FBS) begin
            m_fbs = int'(wr_data[3:0]);
         end
         for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
         m_sync[0] = int'(scl_in);
      end
   end

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         chk("R4/R6", "scl_oe", scl_oe, (m_state == 2));
         chk("R8", "fall_stb", fall_stb, m_fall);
         chk("R8", "high_stb", high_stb, m_high);
         chk("R7", "sda_chg", sda_chg, m_chg);
         chk("R7", "sda_smp", sda_smp, m_smp);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rb(input string req, input logic [7:0] a, input longint exp);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(req, "readback", rd_data, exp);
   endtask

   // enable, count cycles to first low, then the low length and change pulses
   task automatic run_first(input string req_set, input int exp_set, input int exp_low);
      int n, l, cp;
      @(negedge clk);
      en = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!scl_oe && n < 20000);
      chk(req_set, "cycles to first low", n, exp_set);
      chk("R8", "fall strobe at first low", fall_stb, 1);
      l = 0; cp = 0;
      while (scl_oe && l < 20000) begin
         if (sda_chg) cp++;
         l++;
         @(negedge clk);
      end
      chk("R3,R4", "low phase cycles", l, exp_low);
      chk("R7", "change pulses in low phase", cp, 1);
   endtask

   task automatic disable_and_check();
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk("R9", "outputs after disable",
          {scl_oe, fall_stb, high_stb, sda_chg, sda_smp}, 0);
   endtask

   initial begin
      int hs, lo, n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "outputs after reset", {scl_oe, fall_stb, high_stb, sda_chg, sda_smp}, 0);
      rb("R10", CCR, 0);
      rb("R10", FBS, 0);
      cmp_on = 1'b1;

      // R1: field placement, upper bits dropped, stray offset ignored
      wr(CCR, 32'hFFFF_FE2B);
      rb("R1", CCR, 32'h2B);
      wr(8'h1C, 32'hFFFF_FFFF);
      rb("R1", CCR, 32'h2B);
      // R2: setup field readback
      wr(FBS, 32'hFFFF_FFF9);
      rb("R2", FBS, 9);

      // smallest settings: setup 2 ticks, low 10 ticks
      wr(CCR, 0);
      wr(FBS, 0);
      rise_dly = 2;
      run_first("R2", 3, 10);
      repeat (100) @(negedge clk);
      disable_and_check();

      // divider 2, period 1, setup 15 -> 17 ticks
      wr(CCR, (1 << 3) | 2);
      wr(FBS, 15);
      run_first("R2", 52, 42);
      repeat (300) @(negedge clk);
      disable_and_check();

      // R5: stretched line holds off the high count
      wr(CCR, 0);
      wr(FBS, 0);
      rise_dly = 1;
      @(negedge clk);
      en = 1'b1;
      n = 0;
      while (!scl_oe && n < 1000) begin @(negedge clk); n++; end
      stretch = 1'b1;
      while (scl_oe) @(negedge clk);
      hs = 0; lo = 0;
      for (int i = 0; i < 40; i++) begin
         if (high_stb) hs++;
         if (scl_oe) lo++;
         @(negedge clk);
      end
      chk("R5", "high strobes while stretched", hs, 0);
      chk("R5", "low drive while stretched", lo, 0);
      stretch = 1'b0;
      n = 0;
      do begin @(negedge clk); n++; end while (!high_stb && n < 1000);
      chk("R5", "cycles from release to high strobe", n, 1 + 2 + SYNC);
      repeat (60) @(negedge clk);
      disable_and_check();

      // largest settings: divider 7, period 63, setup 3 -> 5 ticks
      rise_dly = 3;
      wr(CCR, (63 << 3) | 7);
      wr(FBS, 3);
      run_first("R2", 41, 2096);
      repeat (1000) @(negedge clk);
      disable_and_check();
      // R9: restart begins with the setup interval again
      run_first("R9", 41, 2096);
      repeat (50) @(negedge clk);
      disable_and_check();

      cmp_on = 1'b0;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=200000 cycles expected=completion before limit");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule